// File: doc/BRIEF.md
# Legacy Display Adapter Register Port Front End

This block decodes byte and word port accesses from a host I/O bus and steers them into the register set of a legacy display adapter. Three register groups (sequencer, graphics control, display timing) are reached through an index latch at a base port and a data window at the next port. A fourth group, the attribute controller, has only one write port. An internal toggle decides whether each write to that port lands in the index latch or in the selected register. Two further byte registers are addressed directly: the miscellaneous output register and an enable register.

Every register read is registered. Read data appears on `rdata_o` on the clock edge that samples the read strobe, and it holds until the next read. Reading the input status port sends the attribute toggle back to its index state. This lets driver software reach a known state before it touches the attribute port. Bit 5 of the attribute index byte drives `video_en_o`. Sequencer register 0 drives `seq_halt_o`.

Top module: `vga_io_regs`

## Requirements
- R1: After reset, all registers and index latches read 0x00, the attribute toggle is in its index state, `video_en_o` is 0, `seq_halt_o` is 1 and `rdata_o` is 0x0000.
- R2: The sequencer (0x3C4), graphics (0x3CE) and display timing (0x3D4) groups take their index at the base port and read back the index there. The register selected by the latched index is read and written at base+1.
- R3: A word write to a group base port loads the index from bits [7:0] and writes bits [15:8] into the register selected by that new index, all in one access.
- R4: The groups hold 5, 9, 25 and 21 registers (attribute). For an index at or beyond the count, data writes are ignored and data reads return 0x00. No register is aliased by truncating the index.
- R5: Writes to 0x3C0 alternate between the index state and the data state, starting in the index state. In the index state, bits [4:0] set the attribute index.
- R6: A read of 0x3DA returns 0x00 and puts the attribute toggle into the index state. The next write to 0x3C0 is then taken as an index.
- R7: A read of 0x3C1 returns the attribute register at the latched index. A read of 0x3C0 returns {2'b00, video bit, index[4:0]}.
- R8: `video_en_o` takes bit 5 of each attribute index write and keeps that value at all other times.
- R9: The miscellaneous register is written at 0x3C2 and read at 0x3CC. A read of 0x3C2 returns 0xFF. The enable register is read and written at 0x3C3.
- R10: Reads of unmapped ports return 0xFF. Writes to 0x3C1, 0x3CC and 0x3DA change no state.
- R11: `rdata_o` is loaded on the clock edge that samples `rd_en_i` and holds when no read is issued. A byte read gives {0x00, byte at addr}. A word read gives {byte at addr+1, byte at addr}. A word write writes the low byte to addr and the high byte to addr+1.
- R12: `seq_halt_o` is 0 only while sequencer register 0 has bits [1:0] = 2'b11. Writing 0x01 halts the sequencer and writing 0x03 releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle |
| rd_en_i | input | 1 | Read strobe, one cycle |
| word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| addr_i | input | 16 | Port address |
| wdata_i | input | 16 | Write data; the low byte goes to addr |
| rdata_o | output | 16 | Registered read data |
| video_en_o | output | 1 | Video output enable |
| seq_halt_o | output | 1 | Sequencer held in reset |

## Verification
The bench targets the attribute toggle. After a status read, it writes an index whose value differs from any data already stored. A design that failed to reset the toggle would store that byte as data and read back the old index. It also writes to the read-only port 0x3C1, which a loose decoder would treat as a toggle step. Out-of-range indices are chosen so that a truncated compare would land on a live register and overwrite it. A word write at a base port checks that the data byte uses the new index and not the stale one.

// File: rtl/vga_io_pkg.sv
package vga_io_pkg;
  localparam int GRP_CNT = 3;
  localparam logic [15:0] GRP_BASE [GRP_CNT] = '{16'h03C4, 16'h03CE, 16'h03D4};
  localparam int GRP_REGS [GRP_CNT] = '{5, 9, 25};
  localparam int ATTR_REGS = 21;
  localparam int ATTR_IW   = 5;
  localparam int VID_BIT   = 5;
  localparam logic [15:0] ATTR_PORT = 16'h03C0;
  localparam logic [15:0] ATTR_RD   = 16'h03C1;
  localparam logic [15:0] MISC_WR   = 16'h03C2;
  localparam logic [15:0] ENA_PORT  = 16'h03C3;
  localparam logic [15:0] MISC_RD   = 16'h03CC;
  localparam logic [15:0] STAT_PORT = 16'h03DA;
  localparam logic [7:0]  OPEN_BUS  = 8'hFF;
  localparam logic [7:0]  STAT_VAL  = 8'h00;
endpackage

// File: rtl/vga_idx_group.sv
module vga_idx_group #(
  parameter int N = 5,
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         idx_we_i,
  input  logic [7:0]   idx_wdata_i,
  input  logic         dat_we_i,
  input  logic [W-1:0] dat_wdata_i,
  output logic [7:0]   idx_o,
  output logic [W-1:0] rd_data_o,
  output logic [W-1:0] reg0_o
);
  logic [7:0]   idx_q;
  logic [7:0]   eff_idx;
  logic [W-1:0] regs [N];

  // a same-cycle index write selects the target of the data byte
  assign eff_idx = idx_we_i ? idx_wdata_i : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_we_i) idx_q <= idx_wdata_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= '0;
      else if (dat_we_i && eff_idx == 8'(i))   q <= dat_wdata_i;
    end
    assign regs[i] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N; i++)
      if (idx_q == 8'(i)) rd_data_o = regs[i];
  end

  assign idx_o  = idx_q;
  assign reg0_o = regs[0];
endmodule

// File: rtl/vga_attr_ctrl.sv
module vga_attr_ctrl
  import vga_io_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       clr_i,
  output logic [7:0] idx_o,
  output logic [7:0] rd_data_o,
  output logic       video_en_o,
  output logic       ff_o
);
  logic       ff_q, vid_q;
  logic [7:0] grp_idx, unused_reg0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q  <= 1'b0;
      vid_q <= 1'b0;
    end else begin
      if (wr_i && !ff_q) vid_q <= wdata_i[VID_BIT];
      // status read wins over a toggle step in the same cycle
      if (clr_i)     ff_q <= 1'b0;
      else if (wr_i) ff_q <= ~ff_q;
    end
  end

  vga_idx_group #(.N(ATTR_REGS), .W(8)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_we_i   (wr_i && !ff_q),
    .idx_wdata_i({{(8-ATTR_IW){1'b0}}, wdata_i[ATTR_IW-1:0]}),
    .dat_we_i   (wr_i && ff_q),
    .dat_wdata_i(wdata_i),
    .idx_o      (grp_idx),
    .rd_data_o  (rd_data_o),
    .reg0_o     (unused_reg0)
  );

  assign idx_o      = {2'b00, vid_q, grp_idx[ATTR_IW-1:0]};
  assign video_en_o = vid_q;
  assign ff_o       = ff_q;
endmodule

// File: rtl/vga_io_regs.sv
module vga_io_regs
  import vga_io_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic        word_i,
  input  logic [15:0] addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        video_en_o,
  output logic        seq_halt_o
);
  logic [15:0] a0, a1;
  logic [7:0]  d0, d1;
  logic        w0, w1, r0, r1;

  assign a0 = addr_i;
  assign a1 = addr_i + 16'd1;
  assign d0 = wdata_i[7:0];
  assign d1 = wdata_i[15:8];
  assign w0 = wr_en_i;
  assign w1 = wr_en_i && word_i;
  assign r0 = rd_en_i;
  assign r1 = rd_en_i && word_i;

  logic [7:0] grp_idx  [GRP_CNT];
  logic [7:0] grp_rd   [GRP_CNT];
  logic [7:0] grp_reg0 [GRP_CNT];

  for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
    localparam logic [15:0] BASE = GRP_BASE[g];
    localparam logic [15:0] DATA = BASE + 16'd1;
    logic       idx_we, dat_we;
    logic [7:0] idx_wd, dat_wd;
    always_comb begin
      idx_we = (w0 && a0 == BASE) || (w1 && a1 == BASE);
      idx_wd = (a0 == BASE) ? d0 : d1;
      dat_we = (w0 && a0 == DATA) || (w1 && a1 == DATA);
      dat_wd = (a0 == DATA) ? d0 : d1;
    end
    vga_idx_group #(.N(GRP_REGS[g]), .W(8)) u_grp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .idx_we_i   (idx_we),
      .idx_wdata_i(idx_wd),
      .dat_we_i   (dat_we),
      .dat_wdata_i(dat_wd),
      .idx_o      (grp_idx[g]),
      .rd_data_o  (grp_rd[g]),
      .reg0_o     (grp_reg0[g])
    );
  end

  logic       attr_wr, stat_clr, attr_ff;
  logic [7:0] attr_wd, attr_idx, attr_rd;

  assign attr_wr  = (w0 && a0 == ATTR_PORT) || (w1 && a1 == ATTR_PORT);
  assign attr_wd  = (a0 == ATTR_PORT) ? d0 : d1;
  assign stat_clr = (r0 && a0 == STAT_PORT) || (r1 && a1 == STAT_PORT);

  vga_attr_ctrl u_attr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (attr_wr),
    .wdata_i   (attr_wd),
    .clr_i     (stat_clr),
    .idx_o     (attr_idx),
    .rd_data_o (attr_rd),
    .video_en_o(video_en_o),
    .ff_o      (attr_ff)
  );

  logic [7:0] misc_q, ena_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      misc_q <= '0;
      ena_q  <= '0;
    end else begin
      if (w0 && a0 == MISC_WR)      misc_q <= d0;
      else if (w1 && a1 == MISC_WR) misc_q <= d1;
      if (w0 && a0 == ENA_PORT)     ena_q  <= d0;
      else if (w1 && a1 == ENA_PORT) ena_q <= d1;
    end
  end

  function automatic logic [7:0] rd_byte(input logic [15:0] a);
    logic [7:0] v;
    v = OPEN_BUS;
    unique case (a)
      ATTR_PORT: v = attr_idx;
      ATTR_RD:   v = attr_rd;
      ENA_PORT:  v = ena_q;
      MISC_RD:   v = misc_q;
      STAT_PORT: v = STAT_VAL;
      default:   v = OPEN_BUS;
    endcase
    for (int g = 0; g < GRP_CNT; g++) begin
      if (a == GRP_BASE[g])         v = grp_idx[g];
      if (a == GRP_BASE[g] + 16'd1) v = grp_rd[g];
    end
    return v;
  endfunction

  logic [15:0] rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= {word_i ? rd_byte(a1) : 8'h00, rd_byte(a0)};
  end

  assign rdata_o    = rdata_q;
  assign seq_halt_o = grp_reg0[0][1:0] != 2'b11;
endmodule

// File: rtl/vga_io_regs_chk.sv
module vga_io_regs_chk
  import vga_io_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        rd_en_i,
  input logic        word_i,
  input logic [15:0] addr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] rdata_o,
  input logic        video_en_o,
  input logic        seq_halt_o,
  input logic        attr_ff
);
  p_ff_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == STAT_PORT) |=> !attr_ff);

  p_ff_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && addr_i == ATTR_PORT) |=> attr_ff != $past(attr_ff));

  p_vid_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ATTR_PORT && !attr_ff) |=> video_en_o == $past(wdata_i[VID_BIT]));

  p_vid_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == ATTR_PORT || (word_i && addr_i == ATTR_PORT - 16'd1)))
    |=> $stable(video_en_o));

  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  p_open_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !word_i && addr_i[15:8] != 8'h03) |=> rdata_o == 16'h00FF);

  p_seq_run_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && word_i && addr_i == GRP_BASE[0] && wdata_i[7:0] == 8'h00 && wdata_i[9:8] == 2'b11)
    |=> !seq_halt_o);
endmodule

bind vga_io_regs vga_io_regs_chk u_chk (.*);

// File: tb/vga_io_regs_test.sv
`timescale 1ns/1ps
module vga_io_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, word = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata;
  logic        video_en, seq_halt;

  int n_run = 0, n_fail = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];
  bit          done = 1'b0;

  always #10 clk = ~clk;

  vga_io_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .word_i(word),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .video_en_o(video_en), .seq_halt_o(seq_halt)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; word = w; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; word = 1'b0;
  endtask

  // driver: queue the expectation, then issue the strobe
  task automatic rd(input logic [15:0] a, input logic w, input logic [15:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1'b1; word = w; addr = a;
    @(negedge clk);
    rd_en = 1'b0; word = 1'b0;
  endtask

  // monitor: data is registered on the edge that samples the strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R11: unexpected read data %h expected none", rdata);
        end else check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", rdata, 16'h0000);
    check("R1 video", {15'd0, video_en}, 16'h0000);
    check("R1 halt", {15'd0, seq_halt}, 16'h0001);
    rd(16'h03C4, 1'b0, 16'h0000, "R1 seq idx");
    rd(16'h03CC, 1'b0, 16'h0000, "R1 misc");
    rd(16'h03C0, 1'b0, 16'h0000, "R1 attr idx");

    // R2 indexed groups
    wr(16'h03C4, 1'b0, 16'h0002);
    wr(16'h03C5, 1'b0, 16'h00A5);
    rd(16'h03C4, 1'b0, 16'h0002, "R2 seq idx");
    rd(16'h03C5, 1'b0, 16'h00A5, "R2 seq data");
    wr(16'h03CE, 1'b0, 16'h0008);
    wr(16'h03CF, 1'b0, 16'h005A);
    rd(16'h03CF, 1'b0, 16'h005A, "R2 gc data");
    wr(16'h03D4, 1'b0, 16'h0018);
    wr(16'h03D5, 1'b0, 16'h003C);
    rd(16'h03D5, 1'b0, 16'h003C, "R2 crtc last reg");

    // R3 word write uses new index
    wr(16'h03D4, 1'b1, 16'h7711);
    rd(16'h03D5, 1'b0, 16'h0077, "R3 crtc data");
    rd(16'h03D4, 1'b0, 16'h0011, "R3 crtc idx");
    rd(16'h03D4, 1'b1, 16'h7711, "R11 word read");
    wr(16'h03D4, 1'b0, 16'h0018);
    rd(16'h03D5, 1'b0, 16'h003C, "R3 old reg untouched");

    // R4 out-of-range index, no aliasing
    wr(16'h03C4, 1'b1, 16'h9905);
    rd(16'h03C5, 1'b0, 16'h0000, "R4 seq oor read");
    rd(16'h03C4, 1'b0, 16'h0005, "R4 seq oor idx");
    wr(16'h03CE, 1'b1, 16'hEE18);
    wr(16'h03CE, 1'b0, 16'h0008);
    rd(16'h03CF, 1'b0, 16'h005A, "R4 gc no alias");

    // R12 sequencer hold/release
    wr(16'h03C4, 1'b1, 16'h0100);
    check("R12 halt on 01", {15'd0, seq_halt}, 16'h0001);
    wr(16'h03C4, 1'b1, 16'h0300);
    check("R12 run on 03", {15'd0, seq_halt}, 16'h0000);

    // R5 R7 R8 attribute toggle
    rd(16'h03DA, 1'b0, 16'h0000, "R6 status");
    wr(16'h03C0, 1'b0, 16'h0023);
    check("R8 video on", {15'd0, video_en}, 16'h0001);
    wr(16'h03C0, 1'b0, 16'h006B);
    check("R8 video held", {15'd0, video_en}, 16'h0001);
    rd(16'h03C1, 1'b0, 16'h006B, "R5 attr data");
    rd(16'h03C0, 1'b0, 16'h0023, "R7 attr idx");
    wr(16'h03C0, 1'b0, 16'h0005);
    check("R8 video off", {15'd0, video_en}, 16'h0000);
    wr(16'h03C0, 1'b0, 16'h0044);
    rd(16'h03C1, 1'b0, 16'h0044, "R7 attr reg5");

    // R6 status read resets toggle mid-sequence
    wr(16'h03C0, 1'b0, 16'h0020);
    rd(16'h03DA, 1'b0, 16'h0000, "R6 status");
    wr(16'h03C0, 1'b0, 16'h0023);
    rd(16'h03C0, 1'b0, 16'h0023, "R6 index after clear");
    rd(16'h03C1, 1'b0, 16'h006B, "R6 reg3 intact");
    wr(16'h03C0, 1'b0, 16'h006B);

    // R4 attribute out of range
    wr(16'h03C0, 1'b0, 16'h0035);
    wr(16'h03C0, 1'b0, 16'h0077);
    rd(16'h03C1, 1'b0, 16'h0000, "R4 attr oor");
    wr(16'h03C0, 1'b0, 16'h0025);
    rd(16'h03C1, 1'b0, 16'h0044, "R4 attr reg5 intact");
    wr(16'h03C0, 1'b0, 16'h0044);

    // R9 misc and enable
    wr(16'h03C2, 1'b0, 16'h00E3);
    rd(16'h03CC, 1'b0, 16'h00E3, "R9 misc read port");
    rd(16'h03C2, 1'b0, 16'h00FF, "R9 misc write port");
    wr(16'h03C3, 1'b0, 16'h0001);
    rd(16'h03C3, 1'b0, 16'h0001, "R9 enable");
    wr(16'h03C2, 1'b1, 16'h00C7);
    rd(16'h03CC, 1'b1, 16'hFFC7, "R11 word misc");
    rd(16'h03C3, 1'b0, 16'h0000, "R9 enable by word");

    // R10 unmapped and read-only ports
    rd(16'h0080, 1'b0, 16'h00FF, "R10 unmapped");
    rd(16'h1000, 1'b1, 16'hFFFF, "R10 unmapped word");
    wr(16'h03C1, 1'b0, 16'h0099);
    wr(16'h03C0, 1'b0, 16'h0023);
    rd(16'h03C1, 1'b0, 16'h006B, "R10 3C1 write ignored");
    wr(16'h03CC, 1'b0, 16'h0011);
    rd(16'h03CC, 1'b0, 16'h00C7, "R10 3CC write ignored");
    wr(16'h03DA, 1'b0, 16'h0055);
    rd(16'h03DA, 1'b0, 16'h0000, "R10 3DA write ignored");

    // R11 hold
    repeat (3) @(negedge clk);
    check("R11 hold", rdata, 16'h0000);
    rd(16'h03C4, 1'b0, 16'h0000, "R11 seq idx");
    repeat (3) @(negedge clk);
    check("R11 queue drained", 16'(exp_q.size()), 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule